// File: doc/BRIEF.md
# Programmable Raster Sync Generator

This block produces the master timing for an interlaced raster. It runs on the pixel clock and keeps a pixel counter and a line counter. From them it drives an active-low horizontal sync and one shared output pin, `fv_o`. In timing mode 1, `fv_o` carries a field indicator. In timing mode 2, it carries an active-low vertical sync pulse. Parameters set the line count (625 or 525), the pixel clocks per line and the number of pixel clocks that make up 32 µs.

One 8-bit timing register shapes the pulses, and a simple write strobe plus a read-back bus give access to it. Widths and delays use a coarse 2-bit code rather than a linear count. The register is copied into an active shadow only at a line start, so a pulse already under way is never cut short. The timing-mode input is sampled at the same point.

Top module: `sync_pulse_top`

## Requirements
- R1: `reg_rdata_o` shows the register contents. Reset clears it to 0x00. In the clock cycle after a cycle with `reg_wr_i` high, it equals the `reg_wdata_i` written in that cycle.
- R2: Register bits [1:0] set the horizontal sync low time: code 0 gives 1 pixel clock, code 1 gives 4, code 2 gives 16 and code 3 gives 128.
- R3: The horizontal sync falls at line pixel D + S, one clock after the counter reaches that pixel. D comes from bits [3:2]: code 0 gives 0, 1 gives 4, 2 gives 8 and 3 gives 16. S is bits [7:6] read as an unsigned number, 0 to 3.
- R4: In timing mode 2 (`timing_mode2_i` = 1), `fv_o` goes low at pixel 0 of line 1 and of line (LINES+1)/2+1. It stays low for the width coded in bits [5:4], using the same code table as R2.
- R5: In timing mode 1, `fv_o` is the field flag: 0 for the first field and 1 for the second. It rises on line (LINES+1)/2+1 and falls on line 1, at pixel D+S when bit 4 is 0 and at pixel D+S+US32_CLKS when bit 4 is 1. Bit 5 has no effect in this mode.
- R6: A register write or a change of `timing_mode2_i` changes the outputs only from the next line start, when the pixel counter wraps to 0.
- R7: While reset is held, `hsync_n_o` is 1, `fv_o` is 0 and `reg_rdata_o` is 0x00. After reset the raster starts at line 1, pixel 0, in timing mode 1.
- R8: A line lasts PIXELS clocks and a frame lasts LINES lines, numbered from 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| timing_mode2_i | input | 1 | 0 selects timing mode 1 (field flag), 1 selects timing mode 2 (vertical sync) |
| reg_wr_i | input | 1 | Write strobe for the timing register |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Timing register read-back |
| hsync_n_o | output | 1 | Horizontal sync, active low, registered |
| fv_o | output | 1 | Field flag (mode 1) or vertical sync, active low (mode 2), registered |

## Verification
The assertions assume PIXELS exceeds both 147 and D+S+US32_CLKS plus one. With that margin, every horizontal pulse and every field edge fits inside one line, and no pulse wraps into the next line. They also assume `timing_mode2_i` and the register inputs change only between clock edges. The bench shortens the raster to 200 pixels by 9 lines with a 40-clock 32 µs span, which keeps it inside those limits. It drives writes and mode flips at random points mid-line, from the falling clock edge, so each change must wait for the next line start.

// File: rtl/sync_gen_pkg.sv
package sync_gen_pkg;

    typedef struct packed {
        logic [1:0] px_shift;
        logic [1:0] fv_ctl;
        logic [1:0] hs_delay;
        logic [1:0] hs_width;
    } tcfg_t;

    // coarse width code shared by horizontal and vertical pulses
    function automatic logic [7:0] width_clks(input logic [1:0] code);
        logic [7:0] w;
        case (code)
            2'd0:    w = 8'd1;
            2'd1:    w = 8'd4;
            2'd2:    w = 8'd16;
            default: w = 8'd128;
        endcase
        return w;
    endfunction

    // horizontal offset code against the field / vertical reference
    function automatic logic [4:0] delay_clks(input logic [1:0] code);
        logic [4:0] d;
        case (code)
            2'd0:    d = 5'd0;
            2'd1:    d = 5'd4;
            2'd2:    d = 5'd8;
            default: d = 5'd16;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/sync_raster_cnt.sv
module sync_raster_cnt #(
    parameter int unsigned PIXELS = 864,
    parameter int unsigned LINES  = 625,
    localparam int unsigned PW    = $clog2(PIXELS),
    localparam int unsigned LW    = $clog2(LINES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [PW-1:0] pix_o,
    output logic [LW-1:0] line_o,
    output logic          line_end_o
);

    typedef struct packed {
        logic [PW-1:0] pix;
        logic [LW-1:0] line;
    } cnt_t;

    cnt_t cnt_d, cnt_q;
    logic last_pix;

    always_comb begin
        cnt_d    = cnt_q;
        last_pix = (cnt_q.pix == PW'(PIXELS - 1));
        if (last_pix) begin
            cnt_d.pix = '0;
            if (cnt_q.line == LW'(LINES)) begin
                cnt_d.line = LW'(1);
            end else begin
                cnt_d.line = cnt_q.line + LW'(1);
            end
        end else begin
            cnt_d.pix = cnt_q.pix + PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q.pix  <= '0;
            cnt_q.line <= LW'(1);
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign pix_o      = cnt_q.pix;
    assign line_o     = cnt_q.line;
    assign line_end_o = last_pix;

endmodule

// File: rtl/sync_pulse_gen.sv
module sync_pulse_gen
    import sync_gen_pkg::*;
#(
    parameter int unsigned PIXELS    = 864,
    parameter int unsigned LINES     = 625,
    parameter int unsigned US32_CLKS = 432,
    localparam int unsigned PW       = $clog2(PIXELS),
    localparam int unsigned LW       = $clog2(LINES + 1),
    localparam int unsigned HALF     = (LINES + 1) / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] pix_i,
    input  logic [LW-1:0] line_i,
    input  tcfg_t         cfg_i,
    input  logic          mode2_i,
    output logic          hsync_n_o,
    output logic          fv_o
);

    typedef struct packed {
        logic hs_n;
        logic fv;
        logic field;
    } gen_t;

    gen_t gen_d, gen_q;
    logic [31:0] p, l, hw, hst, vw, fpos;
    logic        line_a, line_b, hs_win, vs_win;

    always_comb begin
        p      = 32'(pix_i);
        l      = 32'(line_i);
        hw     = 32'(width_clks(cfg_i.hs_width));
        hst    = 32'(delay_clks(cfg_i.hs_delay)) + 32'(cfg_i.px_shift);
        vw     = 32'(width_clks(cfg_i.fv_ctl));
        fpos   = hst + (cfg_i.fv_ctl[0] ? US32_CLKS : 32'd0);
        line_a = (l == 32'd1);
        line_b = (l == HALF + 1);
        hs_win = (p >= hst) && (p < hst + hw);
        vs_win = (line_a || line_b) && (p < vw);

        gen_d      = gen_q;
        gen_d.hs_n = !hs_win;
        if (p == fpos) begin
            if (line_a) begin
                gen_d.field = 1'b0;
            end else if (line_b) begin
                gen_d.field = 1'b1;
            end
        end
        gen_d.fv = mode2_i ? !vs_win : gen_d.field;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gen_q.hs_n  <= 1'b1;
            gen_q.fv    <= 1'b0;
            gen_q.field <= 1'b0;
        end else begin
            gen_q <= gen_d;
        end
    end

    assign hsync_n_o = gen_q.hs_n;
    assign fv_o      = gen_q.fv;

endmodule

// File: rtl/sync_pulse_top.sv
module sync_pulse_top
    import sync_gen_pkg::*;
#(
    parameter int unsigned PIXELS    = 864,
    parameter int unsigned LINES     = 625,
    parameter int unsigned US32_CLKS = 432,
    localparam int unsigned PW       = $clog2(PIXELS),
    localparam int unsigned LW       = $clog2(LINES + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       timing_mode2_i,
    input  logic       reg_wr_i,
    input  logic [7:0] reg_wdata_i,
    output logic [7:0] reg_rdata_o,
    output logic       hsync_n_o,
    output logic       fv_o
);

    typedef struct packed {
        logic [7:0] host;
        tcfg_t      act;
        logic       mode2;
    } top_t;

    top_t st_d, st_q;
    logic [PW-1:0] pix_w;
    logic [LW-1:0] line_w;
    logic          line_end_w;
    logic [7:0]    act_bits;

    sync_raster_cnt #(
        .PIXELS (PIXELS),
        .LINES  (LINES)
    ) cnt_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pix_o      (pix_w),
        .line_o     (line_w),
        .line_end_o (line_end_w)
    );

    always_comb begin
        st_d = st_q;
        if (reg_wr_i) begin
            st_d.host = reg_wdata_i;
        end
        // shadow copy only at the line wrap
        if (line_end_w) begin
            st_d.act   = tcfg_t'(st_q.host);
            st_d.mode2 = timing_mode2_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    sync_pulse_gen #(
        .PIXELS    (PIXELS),
        .LINES     (LINES),
        .US32_CLKS (US32_CLKS)
    ) gen_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pix_i     (pix_w),
        .line_i    (line_w),
        .cfg_i     (st_q.act),
        .mode2_i   (st_q.mode2),
        .hsync_n_o (hsync_n_o),
        .fv_o      (fv_o)
    );

    assign act_bits    = st_q.act;
    assign reg_rdata_o = st_q.host;

endmodule

// File: rtl/sync_pulse_chk.sv
module sync_pulse_chk #(
    parameter int unsigned PIXELS = 864,
    parameter int unsigned LINES  = 625,
    localparam int unsigned PW    = $clog2(PIXELS),
    localparam int unsigned LW    = $clog2(LINES + 1),
    localparam int unsigned HALF  = (LINES + 1) / 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr_i,
    input logic [7:0]    reg_wdata_i,
    input logic [7:0]    reg_rdata_o,
    input logic [PW-1:0] pix_i,
    input logic [LW-1:0] line_i,
    input logic [7:0]    act_i,
    input logic          act_mode2_i,
    input logic          fv_o
);

    AST_RDATA_TRACKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_i |=> (reg_rdata_o == $past(reg_wdata_i))); // R1

    AST_CFG_HOLD_MIDLINE: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_i != '0) |-> ($stable(act_i) && $stable(act_mode2_i))); // R6

    AST_VSYNC_ON_FIELD_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (act_mode2_i && $past(act_mode2_i) && !fv_o)
            |-> ((32'(line_i) == 32'd1) || (32'(line_i) == HALF + 1))); // R4

    AST_FIELD_EDGE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (!act_mode2_i && !$past(act_mode2_i) && !$past(act_mode2_i, 2) && (fv_o != $past(fv_o)))
            |-> ((32'(line_i) == 32'd1) || (32'(line_i) == HALF + 1))); // R5

    AST_RASTER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(pix_i) < PIXELS) && (line_i != '0) && (32'(line_i) <= LINES)); // R8

endmodule

bind sync_pulse_top sync_pulse_chk #(
    .PIXELS (PIXELS),
    .LINES  (LINES)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_i    (reg_wr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .pix_i       (pix_w),
    .line_i      (line_w),
    .act_i       (act_bits),
    .act_mode2_i (st_q.mode2),
    .fv_o        (fv_o)
);

// File: tb/sync_pulse_top_tb.sv
`timescale 1ns/1ps
module sync_pulse_top_tb_top;

    localparam int unsigned P    = 200;
    localparam int unsigned L    = 9;
    localparam int unsigned US   = 40;
    localparam int unsigned HALF = (L + 1) / 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode2 = 1'b0;
    logic       wr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       hs_n, fv;

    int n_run  = 0;
    int n_fail = 0;
    bit chk_en = 1'b0;

    always #2 clk = ~clk;

    sync_pulse_top #(.PIXELS(P), .LINES(L), .US32_CLKS(US)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .timing_mode2_i (mode2),
        .reg_wr_i       (wr),
        .reg_wdata_i    (wdata),
        .reg_rdata_o    (rdata),
        .hsync_n_o      (hs_n),
        .fv_o           (fv)
    );

    function automatic int unsigned wcode(input logic [1:0] c);
        return (c == 0) ? 1 : (c == 1) ? 4 : (c == 2) ? 16 : 128;
    endfunction

    function automatic int unsigned dcode(input logic [1:0] c);
        return (c == 0) ? 0 : (c == 1) ? 4 : (c == 2) ? 8 : 16;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    // reference model of the requirements, one step per clock
    int unsigned m_pix = 0, m_line = 1;
    logic [7:0]  m_reg = 0, m_act = 0;
    logic        m_mode = 0, m_field = 0, e_hs = 1, e_fv = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pix <= 0; m_line <= 1; m_reg <= 0; m_act <= 0;
            m_mode <= 0; m_field <= 0; e_hs <= 1; e_fv <= 0;
        end else begin
            int unsigned hst, fpos;
            logic nf, vwin, onl;
            hst  = dcode(m_act[3:2]) + m_act[7:6];
            fpos = hst + (m_act[4] ? US : 0);
            onl  = (m_line == 1) || (m_line == HALF + 1);
            e_hs <= !((m_pix >= hst) && (m_pix < hst + wcode(m_act[1:0])));
            nf = m_field;
            if (m_pix == fpos) begin
                if (m_line == 1) nf = 0;
                else if (m_line == HALF + 1) nf = 1;
            end
            m_field <= nf;
            vwin = onl && (m_pix < wcode(m_act[5:4]));
            e_fv <= m_mode ? !vwin : nf;
            if (wr) m_reg <= wdata;
            if (m_pix == P - 1) begin
                m_pix  <= 0;
                m_act  <= m_reg;
                m_mode <= mode2;
                m_line <= (m_line == L) ? 1 : m_line + 1;
            end else begin
                m_pix <= m_pix + 1;
            end
        end
    end

    always @(negedge clk) begin
        if (chk_en) begin
            check("R2 R3 R6 R8 hsync", int'(hs_n), int'(e_hs));
            if (m_mode) check("R4 R6 vsync", int'(fv), int'(e_fv));
            else        check("R5 R6 field", int'(fv), int'(e_fv));
            check("R1 readback", int'(rdata), int'(m_reg));
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    task automatic write_reg(input logic [7:0] v);
        @(negedge clk);
        wr = 1'b1; wdata = v;
        @(negedge clk);
        wr = 1'b0;
    endtask

    // horizontal low time, measured at the pins
    task automatic measure_hs(output int w);
        w = 0;
        @(negedge clk);
        while (hs_n == 1'b0) @(negedge clk);
        while (hs_n == 1'b1) @(negedge clk);
        while (hs_n == 1'b0) begin w++; @(negedge clk); end
    endtask

    task automatic measure_fv_low(output int w);
        w = 0;
        @(negedge clk);
        while (fv == 1'b0) @(negedge clk);
        while (fv == 1'b1) @(negedge clk);
        while (fv == 1'b0) begin w++; @(negedge clk); end
    endtask

    // clocks from horizontal fall to field rise
    task automatic measure_field_lag(output int lag);
        logic phs, pfv;
        int since;
        since = 0; lag = -1;
        @(negedge clk); phs = hs_n; pfv = fv;
        while (lag < 0) begin
            @(negedge clk);
            if (phs && !hs_n) since = 0; else since++;
            if (!pfv && fv) lag = since;
            phs = hs_n; pfv = fv;
        end
    endtask

    initial begin
        int w;
        void'($urandom(32'd7714));
        repeat (3) @(negedge clk);
        check("R7 reset hsync", int'(hs_n), 1);
        check("R7 reset fv", int'(fv), 0);
        check("R7 reset rdata", int'(rdata), 0);
        rst_n = 1'b1;
        chk_en = 1'b1;
        // R2 width table, bits [1:0]
        for (int c = 0; c < 4; c++) begin
            write_reg(8'(c));
            repeat (2 * P) @(negedge clk);
            measure_hs(w);
            check("R2 hsync width", w, int'(wcode(2'(c))));
        end
        // R4 vertical width table, bits [5:4]
        mode2 = 1'b1;
        for (int c = 0; c < 4; c++) begin
            write_reg(8'(c << 4));
            repeat (2 * P) @(negedge clk);
            measure_fv_low(w);
            check("R4 vsync width", w, int'(wcode(2'(c))));
        end
        // R5 field lag, bit 4 set and clear, bit 5 ignored
        mode2 = 1'b0;
        write_reg(8'h30);
        repeat (2 * P) @(negedge clk);
        measure_field_lag(w);
        check("R5 field lag +32us", w, int'(US));
        write_reg(8'h20);
        repeat (2 * P) @(negedge clk);
        measure_field_lag(w);
        check("R5 field lag base", w, 0);
        // random mid-line writes and mode flips (R6, R3)
        for (int i = 0; i < 40; i++) begin
            repeat ($urandom_range(700, 1)) @(negedge clk);
            if ($urandom_range(3, 0) == 0) mode2 = ~mode2;
            write_reg(8'($urandom));
        end
        write_reg(8'hFF);
        repeat (2 * P * L) @(negedge clk);
        mode2 = 1'b1;
        repeat (2 * P * L) @(negedge clk);
        chk_en = 1'b0;
        summary();
    end

endmodule